// File: doc/BRIEF.md
# Two-Channel Sequential Breakpoint Unit

This block watches a processor's bus cycles through two comparison channels, A and B. Each channel is tied to one of two buses and matches on an address, on a cycle type (instruction fetch or data access) and, for data cycles, on a read/write direction. A match can raise a break request on its own. In sequential mode, the break is raised only when channel B matches in a bus cycle strictly later than the one in which channel A matched.

A match does not always become a break. The unit weighs each matched condition against the exception indications that come with the same bus cycle. Fetch matches are pre-execution breaks and take priority over every other exception. Data matches give way to re-execution exceptions, traps and data address errors, and each of these case sets the sticky condition-match flags in its own way. A fetch match on the delay-slot instruction of a return-from-exception is held back and taken on the next fetch.

Software configures the unit through a small register port. Writes take effect for bus cycles after the write edge, and a readback returns the value just written. During module standby the unit raises no breaks and its register port is inert.

Top module: `seq_break_unit`

## Requirements
- R1: After reset, brkReq, brkPre and matchFlags are 0, and every register reads back 0.
- R2: The register index regSel selects one of four registers: 0 is the channel A compare address, 1 is the channel B compare address, 2 is the configuration and 3 is the status. A write with regWe high is stored at the clock edge. A bus cycle at that same edge still uses the old value. regRdata returns the new value combinationally from the following cycle on.
- R3: The configuration holds channel A in bits 4:0 and channel B in bits 9:5, each laid out as enable[0], bus[1], fetch[2], read[3], write[4]. Bit 10 selects sequential mode. A bus cycle with busValid high matches a channel when all of these hold: the channel is enabled, busSel equals the bus bit, busAddr equals the compare address, and the type fits. Fitting means a fetch cycle when fetch=1, or otherwise a data cycle whose direction (busWrite) has its read or write bit set. A break that is not suppressed shows as brkReq high for exactly the cycle after the bus cycle.
- R4: brkPre is high together with brkReq when the break comes from a fetch match, and low when the break comes from a data match.
- R5: In sequential mode, only channel B raises a break. A channel A match arms the unit and sets flag A, and status bit 2 reads as the armed state. A B match raises a break only if the unit was armed before that bus cycle. A single cycle that matches both channels while the unit is unarmed gives no break, but it leaves the unit armed.
- R6: A fetch-match break is issued and its flag is set whatever the exception inputs are.
- R7: The armed state persists across idle and non-matching cycles. It clears when a sequential break fires, and also on any configuration write.
- R8: A data match together with excReexec gives no break and leaves the flag clear.
- R9: A data match together with excTrap gives no break but sets the channel's flag.
- R10: A data match together with excAddrErr gives no break but sets the channel's flag.
- R11: A fetch match with rteSlot high gives no break at that cycle. The break is taken, with brkPre and the flag set, on the next fetch cycle with rteSlot low, whatever that cycle's address is.
- R12: While standby is high, the unit issues no break, does not change the flags, ignores register writes and reads 0.
- R13: matchFlags (status bits 1:0, A in bit 0) are sticky. A status write clears each flag whose bit is written as 0 and leaves the flags written as 1 unchanged. A match that sets a flag in the same cycle as a clearing write wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Module standby; breaks and register access disabled |
| busValid | input | 1 | A bus cycle is present this clock |
| busSel | input | 1 | Bus carrying the cycle (0 local, 1 internal) |
| busAddr | input | WIDTH | Bus cycle address |
| busWrite | input | 1 | Data cycle direction, 1 = write |
| busFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| excReexec | input | 1 | Re-execution-type exception on the same instruction |
| excTrap | input | 1 | Completion-type trap on the same instruction |
| excAddrErr | input | 1 | Data address error on the same instruction |
| rteSlot | input | 1 | Cycle is the delay slot of a return-from-exception |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register index |
| regWdata | input | WIDTH | Register write data |
| regRdata | output | WIDTH | Register read data for regSel |
| brkReq | output | 1 | Break request, one cycle after the deciding bus cycle |
| brkPre | output | 1 | Break is a pre-execution break |
| matchFlags | output | 2 | Sticky condition-match flags, A in bit 0 |

## Verification
On every clock cycle, the assertions check four things: the unit is silent in standby, the unit is silent in sequential mode until it is armed, a re-execution exception always suppresses a data break, and brkPre never appears without brkReq. They also check that flags stay sticky and that a configuration write disarms the unit. Only the bench scenarios can show the decoding of each configuration field against each bus cycle type, the strict ordering of A before B, the different flag outcomes for traps and address errors, the deferral out of a return delay slot, and the one-cycle latency of a register write.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam logic [1:0] REG_ADDR_A = 2'd0;
  localparam logic [1:0] REG_ADDR_B = 2'd1;
  localparam logic [1:0] REG_CFG    = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;
  localparam int NUM_CH    = 2;
  localparam int CH_CFG_W  = 5;
  localparam int SEQ_BIT   = NUM_CH * CH_CFG_W;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic fetch;
    logic bus;
    logic en;
  } chanCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0] setFlag;
    logic              setArmed;
    logic              clrArmed;
  } ctlStrobe_t;
endpackage

// File: rtl/sbu_datapath.sv
module sbu_datapath
  import sbu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic              busValid,
  input  logic              busSel,
  input  logic [WIDTH-1:0]  busAddr,
  input  logic              busWrite,
  input  logic              busFetch,
  input  ctlStrobe_t        ctl,
  output logic [NUM_CH-1:0] matchVec,
  output logic              seqMode,
  output logic              armed,
  output logic [NUM_CH-1:0] flags
);
  logic [WIDTH-1:0] cmpAddr [NUM_CH];
  chanCfg_t         cfgCh   [NUM_CH];
  logic             wrOk;
  logic             cfgWr;
  logic             statusWr;

  assign wrOk     = regWe && !standby;
  assign cfgWr    = wrOk && (regSel == REG_CFG);
  assign statusWr = wrOk && (regSel == REG_STATUS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        cmpAddr[i] <= '0;
        cfgCh[i]   <= '0;
      end
      seqMode <= 1'b0;
    end else if (wrOk) begin
      case (regSel)
        REG_ADDR_A: cmpAddr[0] <= regWdata;
        REG_ADDR_B: cmpAddr[1] <= regWdata;
        REG_CFG: begin
          for (int i = 0; i < NUM_CH; i++)
            cfgCh[i] <= chanCfg_t'(regWdata[i*CH_CFG_W +: CH_CFG_W]);
          seqMode <= regWdata[SEQ_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctl.setFlag[i])                flags[i] <= 1'b1;
        else if (statusWr && !regWdata[i]) flags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 armed <= 1'b0;
    else if (cfgWr || standby) armed <= 1'b0;
    else if (ctl.setArmed)     armed <= 1'b1;
    else if (ctl.clrArmed)     armed <= 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gChan
      logic typeOk;
      assign typeOk = cfgCh[g].fetch ? busFetch
                    : (!busFetch && (busWrite ? cfgCh[g].wrEn : cfgCh[g].rdEn));
      assign matchVec[g] = !standby && busValid && cfgCh[g].en &&
                           (busSel == cfgCh[g].bus) &&
                           (busAddr == cmpAddr[g]) && typeOk;

      // R13: a set flag survives unless a status write clears it
      a_r13_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (flags[g] && !(regWe && !standby && regSel == REG_STATUS && !regWdata[g]))
          |=> flags[g]);
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    if (!standby) begin
      case (regSel)
        REG_ADDR_A: regRdata = cmpAddr[0];
        REG_ADDR_B: regRdata = cmpAddr[1];
        REG_CFG: begin
          for (int i = 0; i < NUM_CH; i++)
            regRdata[i*CH_CFG_W +: CH_CFG_W] = cfgCh[i];
          regRdata[SEQ_BIT] = seqMode;
        end
        default: begin
          regRdata[NUM_CH-1:0] = flags;
          regRdata[NUM_CH]     = armed;
        end
      endcase
    end
  end

  // R7: reconfiguration leaves the sequence disarmed
  a_r7_cfg_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !standby && regSel == REG_CFG) |=> !armed);
endmodule

// File: rtl/sbu_control.sv
module sbu_control
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              busValid,
  input  logic              busFetch,
  input  logic              excReexec,
  input  logic              excTrap,
  input  logic              excAddrErr,
  input  logic              rteSlot,
  input  logic [NUM_CH-1:0] matchVec,
  input  logic              seqMode,
  input  logic              armed,
  output ctlStrobe_t        ctl,
  output logic              brkReq,
  output logic              brkPre
);
  logic [NUM_CH-1:0] cond;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] pendSet;
  logic              pendFire;
  logic              brkNow;
  logic              preNow;

  always_comb begin
    ctl      = '0;
    brkNow   = 1'b0;
    preNow   = 1'b0;
    pendSet  = '0;
    cond[0]  = !seqMode && matchVec[0];
    cond[1]  = matchVec[1] && (!seqMode || armed);
    ctl.setArmed = seqMode && matchVec[0];
    if (ctl.setArmed) ctl.setFlag[0] = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cond[i]) begin
        if (busFetch) begin
          if (rteSlot) begin
            pendSet[i] = 1'b1;
          end else begin
            brkNow = 1'b1;
            preNow = 1'b1;
            ctl.setFlag[i] = 1'b1;
          end
        end else if (excReexec) begin
          // instruction is re-executed: condition is judged again later
        end else if (excTrap || excAddrErr) begin
          ctl.setFlag[i] = 1'b1;
        end else begin
          brkNow = 1'b1;
          ctl.setFlag[i] = 1'b1;
        end
      end
    end
    ctl.clrArmed = seqMode && cond[1] && (busFetch || !excReexec);
    pendFire = !standby && busValid && busFetch && !rteSlot && (pend != '0);
    if (pendFire) begin
      brkNow = 1'b1;
      preNow = 1'b1;
      ctl.setFlag = ctl.setFlag | pend;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend   <= '0;
      brkReq <= 1'b0;
      brkPre <= 1'b0;
    end else begin
      pend   <= standby ? '0 : ((pendFire ? '0 : pend) | pendSet);
      brkReq <= brkNow;
      brkPre <= preNow;
    end
  end

  // R12: no break follows a standby cycle
  a_r12_standby_quiet: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> !brkReq);
  // R5: sequential mode stays silent until armed
  a_r5_seq_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && !armed && pend == '0) |=> !brkReq);
  // R8: re-execution always suppresses a data-cycle break
  a_r8_reexec_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busFetch && excReexec) |=> !brkReq);
  // R4: pre-execution marker only accompanies a break
  a_r4_pre_with_req: assert property (@(posedge clk) disable iff (!rstN)
    brkPre |-> brkReq);
endmodule

// File: rtl/seq_break_unit.sv
module seq_break_unit
  import sbu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             busValid,
  input  logic             busSel,
  input  logic [WIDTH-1:0] busAddr,
  input  logic             busWrite,
  input  logic             busFetch,
  input  logic             excReexec,
  input  logic             excTrap,
  input  logic             excAddrErr,
  input  logic             rteSlot,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  output logic             brkReq,
  output logic             brkPre,
  output logic [1:0]       matchFlags
);
  ctlStrobe_t        ctl;
  logic [NUM_CH-1:0] matchVec;
  logic              seqMode;
  logic              armed;

  sbu_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .standby(standby),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .busValid(busValid), .busSel(busSel), .busAddr(busAddr),
    .busWrite(busWrite), .busFetch(busFetch),
    .ctl(ctl), .matchVec(matchVec), .seqMode(seqMode), .armed(armed),
    .flags(matchFlags)
  );

  sbu_control uCtrl (
    .clk(clk), .rstN(rstN), .standby(standby),
    .busValid(busValid), .busFetch(busFetch),
    .excReexec(excReexec), .excTrap(excTrap), .excAddrErr(excAddrErr),
    .rteSlot(rteSlot), .matchVec(matchVec), .seqMode(seqMode), .armed(armed),
    .ctl(ctl), .brkReq(brkReq), .brkPre(brkPre)
  );
endmodule

// File: tb/tb_seq_break_unit.sv
module tb_seq_break_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standby = 1'b0;
  logic        busValid = 1'b0, busSel = 1'b0, busWrite = 1'b0, busFetch = 1'b0;
  logic [15:0] busAddr = '0;
  logic        excReexec = 1'b0, excTrap = 1'b0, excAddrErr = 1'b0, rteSlot = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        brkReq, brkPre;
  logic [1:0]  matchFlags;
  int checks = 0;
  int failures = 0;
  logic [15:0] rd;

  seq_break_unit #(.WIDTH(16)) dut (
    .clk(clk), .rstN(rstN), .standby(standby), .busValid(busValid),
    .busSel(busSel), .busAddr(busAddr), .busWrite(busWrite), .busFetch(busFetch),
    .excReexec(excReexec), .excTrap(excTrap), .excAddrErr(excAddrErr),
    .rteSlot(rteSlot), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .brkReq(brkReq), .brkPre(brkPre), .matchFlags(matchFlags)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements) actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busIdle();
    busValid = 0; busSel = 0; busAddr = '0; busWrite = 0; busFetch = 0;
    excReexec = 0; excTrap = 0; excAddrErr = 0; rteSlot = 0;
  endtask

  task automatic busCyc(input logic sel, input logic [15:0] addr, input logic wr,
                        input logic fetch, input logic rx, input logic tr,
                        input logic ae, input logic rte);
    busValid = 1; busSel = sel; busAddr = addr; busWrite = wr; busFetch = fetch;
    excReexec = rx; excTrap = tr; excAddrErr = ae; rteSlot = rte;
    @(posedge clk); #1;
    busIdle();
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] data);
    regWe = 1; regSel = sel; regWdata = data;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] data);
    regSel = sel; #1; data = regRdata;
  endtask

  task automatic idleCyc();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 brkReq", {15'b0, brkReq}, 16'h0);
    check("R1 brkPre", {15'b0, brkPre}, 16'h0);
    check("R1 flags", {14'b0, matchFlags}, 16'h0);
    for (int r = 0; r < 4; r++) begin
      readReg(r[1:0], rd);
      check("R1 reg readback", rd, 16'h0);
    end

    // R2 readback and write latency
    writeReg(2'd2, 16'h0019);                  // A: en, bus0, data, rd, wr
    readReg(2'd2, rd); check("R2 cfg readback", rd, 16'h0019);
    regWe = 1; regSel = 2'd0; regWdata = 16'h0055;
    busValid = 1; busAddr = 16'h0055;          // same edge as the write
    @(posedge clk); #1; regWe = 0; busIdle();
    check("R2 old addr used at write edge", {15'b0, brkReq}, 16'h0);
    readReg(2'd0, rd); check("R2 addr readback", rd, 16'h0055);
    busCyc(0, 16'h0055, 0, 0, 0, 0, 0, 0);
    check("R2 new addr active next cycle", {15'b0, brkReq}, 16'h1);

    // R3/R4 sweep over channel A configurations and bus cycles
    writeReg(2'd0, 16'h1234);
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int rw = 1; rw < 4; rw++) begin
          writeReg(2'd2, 16'(1 | (b << 1) | (f << 2) | (rw << 3)));
          for (int cb = 0; cb < 2; cb++)
            for (int cf = 0; cf < 2; cf++)
              for (int cw = 0; cw < 2; cw++)
                for (int hit = 0; hit < 2; hit++) begin
                  logic exp;
                  exp = (hit == 1) && (cb == b) &&
                        ((f == 1) ? (cf == 1) : ((cf == 0) && ((cw == 1) ? rw[1] : rw[0])));
                  busCyc(cb[0], hit ? 16'h1234 : 16'h1235, cw[0], cf[0], 0, 0, 0, 0);
                  check("R3 match decode", {15'b0, brkReq}, {15'b0, exp});
                  if (exp) check("R4 break type", {15'b0, brkPre}, {15'b0, f[0]});
                  else     check("R4 no pre without break", {15'b0, brkPre}, 16'h0);
                end
        end
    idleCyc();
    check("R3 pulse lasts one cycle", {15'b0, brkReq}, 16'h0);
    // channel B alone
    writeReg(2'd1, 16'h0200);
    writeReg(2'd2, 16'h0019 << 5);
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0200, 1, 0, 0, 0, 0, 0);
    check("R3 channel B break", {15'b0, brkReq}, 16'h1);
    check("R3 channel B flag", {14'b0, matchFlags}, 16'h2);

    // R5 sequential ordering
    writeReg(2'd0, 16'h0100);
    writeReg(2'd2, 16'h0739);
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0200, 0, 0, 0, 0, 0, 0);
    check("R5 B before A no break", {15'b0, brkReq}, 16'h0);
    busCyc(0, 16'h0100, 0, 0, 0, 0, 0, 0);
    check("R5 A alone no break", {15'b0, brkReq}, 16'h0);
    readReg(2'd3, rd); check("R5 armed and flag A", rd, 16'h0005);
    idleCyc(); idleCyc();
    readReg(2'd3, rd); check("R7 armed held over idle", rd[2], 1'b1);
    busCyc(0, 16'h0300, 0, 0, 0, 0, 0, 0);
    readReg(2'd3, rd); check("R7 armed held over miss", rd[2], 1'b1);
    busCyc(0, 16'h0200, 0, 0, 0, 0, 0, 0);
    check("R5 A then B breaks", {15'b0, brkReq}, 16'h1);
    check("R5 data break not pre", {15'b0, brkPre}, 16'h0);
    readReg(2'd3, rd); check("R7 disarmed after fire, both flags", rd, 16'h0003);
    writeReg(2'd1, 16'h0100);                  // B shares A's address
    busCyc(0, 16'h0100, 0, 0, 0, 0, 0, 0);
    check("R5 same-cycle A and B no break", {15'b0, brkReq}, 16'h0);
    readReg(2'd3, rd); check("R5 same-cycle arms", rd[2], 1'b1);
    busCyc(0, 16'h0100, 0, 0, 0, 0, 0, 0);
    check("R5 later B after armed breaks", {15'b0, brkReq}, 16'h1);
    // R7 reconfiguration disarms
    writeReg(2'd1, 16'h0200);
    busCyc(0, 16'h0100, 0, 0, 0, 0, 0, 0);
    writeReg(2'd2, 16'h0739);
    readReg(2'd3, rd); check("R7 cfg write disarms", rd[2], 1'b0);
    busCyc(0, 16'h0200, 0, 0, 0, 0, 0, 0);
    check("R7 B after reconfig no break", {15'b0, brkReq}, 16'h0);

    // R8-R10 data break versus competing exceptions
    writeReg(2'd2, 16'h0019);
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0100, 0, 0, 1, 0, 0, 0);
    check("R8 reexec no break", {15'b0, brkReq}, 16'h0);
    check("R8 reexec flag clear", {14'b0, matchFlags}, 16'h0);
    busCyc(0, 16'h0100, 0, 0, 0, 1, 0, 0);
    check("R9 trap no break", {15'b0, brkReq}, 16'h0);
    check("R9 trap sets flag", {14'b0, matchFlags}, 16'h1);
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0100, 1, 0, 0, 0, 1, 0);
    check("R10 addr error no break", {15'b0, brkReq}, 16'h0);
    check("R10 addr error sets flag", {14'b0, matchFlags}, 16'h1);
    busCyc(0, 16'h0100, 1, 0, 0, 0, 0, 0);
    check("R10 plain data break", {15'b0, brkReq}, 16'h1);

    // R6 pre-execution wins
    writeReg(2'd2, 16'h0005);
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0100, 0, 1, 1, 1, 1, 0);
    check("R6 fetch break despite exceptions", {15'b0, brkReq}, 16'h1);
    check("R6 pre flag", {15'b0, brkPre}, 16'h1);
    check("R6 flag set", {14'b0, matchFlags}, 16'h1);

    // R11 return delay slot deferral
    writeReg(2'd3, 16'h0000);
    busCyc(0, 16'h0100, 0, 1, 0, 0, 0, 1);
    check("R11 no break in delay slot", {15'b0, brkReq}, 16'h0);
    check("R11 flag deferred", {14'b0, matchFlags}, 16'h0);
    busCyc(0, 16'h0700, 0, 0, 0, 0, 0, 0);
    check("R11 data cycle does not take it", {15'b0, brkReq}, 16'h0);
    busCyc(1, 16'h0300, 0, 1, 0, 0, 0, 0);
    check("R11 taken at branch target", {15'b0, brkReq}, 16'h1);
    check("R11 taken as pre", {15'b0, brkPre}, 16'h1);
    check("R11 flag set when taken", {14'b0, matchFlags}, 16'h1);

    // R12 standby
    writeReg(2'd3, 16'h0000);
    standby = 1;
    busCyc(0, 16'h0100, 0, 1, 0, 0, 0, 0);
    check("R12 no break in standby", {15'b0, brkReq}, 16'h0);
    check("R12 flags unchanged", {14'b0, matchFlags}, 16'h0);
    readReg(2'd0, rd); check("R12 read zero", rd, 16'h0000);
    writeReg(2'd0, 16'h0999);
    standby = 0;
    readReg(2'd0, rd); check("R12 write ignored", rd, 16'h0100);

    // R13 sticky flags
    busCyc(0, 16'h0100, 0, 1, 0, 0, 0, 0);
    idleCyc();
    check("R13 flag sticky", {14'b0, matchFlags}, 16'h1);
    writeReg(2'd3, 16'h0003);
    check("R13 write one keeps flag", {14'b0, matchFlags}, 16'h1);
    regWe = 1; regSel = 2'd3; regWdata = 16'h0000;
    busValid = 1; busAddr = 16'h0100; busFetch = 1;
    @(posedge clk); #1; regWe = 0; busIdle();
    check("R13 set wins over clear", {14'b0, matchFlags}, 16'h1);
    writeReg(2'd3, 16'h0002);
    check("R13 write zero clears", {14'b0, matchFlags}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule